// File: doc/BRIEF.md
# Bitmap Block Copy Engine

This block moves a rectangular window of 16-bit words from memory to memory. Up to three source channels (A, B and C) are read and one destination channel (D) is written. The window is walked one word at a time and one line at a time. Each channel has its own pointer, which moves by 2 bytes per word. At every line end the channel's signed byte modulo is also added, so the window can be a sub-rectangle of a wider bitmap.

Source A and source B each pass through a barrel shifter, so graphics can be placed at any bit position. Bits pushed out of one word enter the next word of the same line. Source A also carries a mask for the first word of each line and a mask for the last word. The three sources are then combined bit by bit through an 8-bit truth table.

A channel that is switched off is not fetched. It reuses the word last written to its data register, which makes pattern fills and constant operands cheap. Software sets up the configuration registers and starts the job by writing the size register. It then waits for the busy flag to fall and reads the zero flag, which is useful for collision tests.

Top module: `blkc_engine`

## Requirements
- R1: Writing the size register (address 15; height in lines in bits 15:6, width in words in bits 5:0) while idle starts a job. A zero field means 1024 lines or 64 words. `busy` is high from the clock after that write until the last access of the job has completed.
- R2: Each output bit is bit {a,b,c} of the function code (register 1, bits 7:0), with a as the most significant index bit. So 0xF0 gives A, 0x0F gives not A, and 0xCA gives (A and B) or (not A and C).
- R3: The mode register (address 0) holds the A shift in bits 15:12 and the B shift in bits 11:8. In ascending order, a channel's output is the low 16 bits of {previous word, current word} shifted right. The shift adds no cycles.
- R4: Source A is ANDed with the first-word mask (register 2) on a line's first word and with the last-word mask (register 3) on its last word. A one-word-wide window gets both masks.
- R5: After each word, an enabled channel's pointer (registers 4 to 7, byte addresses for A, B, C, D) moves by 2. At a line end it also moves by the channel's signed modulo (registers 8 to 11). A following job with no pointer reload continues from the resulting addresses.
- R6: With mode bit 0 set (descending), pointers start at the bottom-right word and move down by 2 plus the modulo. The shift then works leftward: the output is the high 16 bits of {current, previous} shifted left.
- R7: A channel whose enable bit is clear (mode bit 7 = A, 6 = B, 5 = C, 4 = D) makes no memory access. For A, B and C the value last written to its data register (addresses 12, 13, 14) is used instead.
- R8: `zero` is 1 after a job exactly when every output bit of that job was 0. This holds even when the destination is disabled, in which case nothing is written.
- R9: For each word the accesses run in the order A read, B read, C read, D write. Each request holds its address and direction until `mem_ack`.
- R10: The shifter's previous-word stores clear at the start of every line, so no bits carry from one line into the next.
- R11: After reset, `busy` and `zero` are 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 16 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (destination), 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Destination write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completion |
| busy | output | 1 | Job in progress |
| zero | output | 1 | Every output bit of the last job was 0 |

## Verification
`busy` rises on the first clock edge after the size write, so the bench samples it at the next falling edge. Memory contents and the `zero` flag are final once `busy` is low. The bench waits for that falling edge, with a cycle limit, before it reads its memory model or the flag. The access log is kept by the memory model on the same edges where it acknowledges requests, so the order and count of accesses are checked after the job ends and do not depend on when the bench samples.

// File: rtl/blkc_pkg.sv
// Package: shared constants and the sequencer state type for the block copy engine.
// Assumes 16-bit data words and byte addressing with 2 bytes per word.
package blkc_pkg;
    localparam int WORD_W = 16;
    localparam int SH_W   = 4;
    localparam int NCH    = 4;

    // register addresses
    localparam logic [3:0] RA_MODE  = 4'd0;
    localparam logic [3:0] RA_FUNC  = 4'd1;
    localparam logic [3:0] RA_FMASK = 4'd2;
    localparam logic [3:0] RA_LMASK = 4'd3;
    localparam logic [3:0] RA_PTR0  = 4'd4;
    localparam logic [3:0] RA_MOD0  = 4'd8;
    localparam logic [3:0] RA_DATA0 = 4'd12;
    localparam logic [3:0] RA_SIZE  = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_RDC,
        ST_WRD
    } blkc_state_t;
endpackage

// File: rtl/blkc_ptr_bank.sv
// Module: pointer and modulo registers for the four channels.
// Each channel steps by 2 bytes per word, plus its signed modulo at a line end,
// upward or downward. Assumes writes and steps never occur in the same cycle.
module blkc_ptr_bank #(
    parameter int AW = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_ptr,
    input  logic                           wr_mod,
    input  logic [1:0]                     wr_sel,
    input  logic [blkc_pkg::WORD_W-1:0]    wr_data,
    input  logic                           step,
    input  logic [blkc_pkg::NCH-1:0]       step_en,
    input  logic                           line_end,
    input  logic                           desc,
    output logic [blkc_pkg::NCH-1:0][AW-1:0] ptr_o
);
    import blkc_pkg::*;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [AW-1:0]     ptr_q;
        logic [WORD_W-1:0] mod_q;
        logic [AW-1:0]     mod_ext;
        logic [AW-1:0]     delta;

        // sign-extend the byte modulo and form this word's step size
        always_comb begin
            mod_ext = AW'($signed(mod_q));
            delta   = line_end ? (AW'(2) + mod_ext) : AW'(2);
        end

        // hold the pointer; load from software or advance after each word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else if (wr_ptr && wr_sel == 2'(ch)) begin
                ptr_q <= AW'(wr_data);
            end else if (step && step_en[ch]) begin
                ptr_q <= desc ? (ptr_q - delta) : (ptr_q + delta);
            end
        end

        // hold the modulo written by software
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_q <= '0;
            end else if (wr_mod && wr_sel == 2'(ch)) begin
                mod_q <= wr_data;
            end
        end

        assign ptr_o[ch] = ptr_q;
    end
endmodule

// File: rtl/blkc_shift.sv
// Module: cross-word barrel shifter for one source channel (combinational).
// Ascending: shifts right, taking the low bits of the previous word.
// Descending: shifts left, taking the high bits of the previous word.
module blkc_shift (
    input  logic [blkc_pkg::WORD_W-1:0] cur,
    input  logic [blkc_pkg::WORD_W-1:0] prev,
    input  logic [blkc_pkg::SH_W-1:0]   amount,
    input  logic                        desc,
    output logic [blkc_pkg::WORD_W-1:0] out
);
    import blkc_pkg::*;

    logic [2*WORD_W-1:0] right_w;
    logic [2*WORD_W-1:0] left_w;

    // build both directions and pick the one for the current order
    always_comb begin
        right_w = {prev, cur} >> amount;
        left_w  = {cur, prev} << amount;
        out     = desc ? left_w[2*WORD_W-1:WORD_W] : right_w[WORD_W-1:0];
    end
endmodule

// File: rtl/blkc_minterm.sv
// Module: bitwise three-input truth-table combiner (combinational).
// Each output bit is func[{a,b,c}] for that bit position.
module blkc_minterm (
    input  logic [7:0]                  func,
    input  logic [blkc_pkg::WORD_W-1:0] a,
    input  logic [blkc_pkg::WORD_W-1:0] b,
    input  logic [blkc_pkg::WORD_W-1:0] c,
    output logic [blkc_pkg::WORD_W-1:0] d
);
    import blkc_pkg::*;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign d[i] = func[{a[i], b[i], c[i]}];
    end
endmodule

// File: rtl/blkc_engine.sv
// Module: top of the block copy engine.
// Walks a window word by word, reads the enabled sources in the order A, B, C,
// combines them and writes D. Registers accept writes only while idle.
// Assumes the memory holds mem_rdata valid in the cycle mem_ack is high.
module blkc_engine #(
    parameter int AW = 16,
    parameter int HW = 10,
    parameter int WW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [3:0]                  cfg_addr,
    input  logic [blkc_pkg::WORD_W-1:0] cfg_wdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [AW-1:0]               mem_addr,
    output logic [blkc_pkg::WORD_W-1:0] mem_wdata,
    input  logic [blkc_pkg::WORD_W-1:0] mem_rdata,
    input  logic                        mem_ack,
    output logic                        busy,
    output logic                        zero
);
    import blkc_pkg::*;

    localparam int COLW = WW + 1;
    localparam int ROWW = HW + 1;
    localparam logic [COLW-1:0] WMAX = COLW'(1) << WW;
    localparam logic [ROWW-1:0] HMAX = ROWW'(1) << HW;
    localparam logic [WORD_W-1:0] ONES = '1;

    blkc_state_t state_q;
    logic [WORD_W-1:0] mode_q, fmask_q, lmask_q;
    logic [7:0]        func_q;
    logic [WORD_W-1:0] dat_a_q, dat_b_q, dat_c_q;
    logic [WORD_W-1:0] prev_a_q, prev_b_q;
    logic [HW-1:0]     height_q;
    logic [WW-1:0]     width_q;
    logic [COLW-1:0]   col_q, width_n;
    logic [ROWW-1:0]   row_q, height_n;
    logic              zero_q;

    logic              idle, cfg_ok, start;
    logic              en_a, en_b, en_c, en_d, desc;
    logic              first_w, last_w, last_r, word_done;
    logic [WORD_W-1:0] amask, a_masked, a_sh, b_sh, d_val;
    logic [NCH-1:0][AW-1:0] ptr;

    // decode control fields and window position
    always_comb begin
        idle     = (state_q == ST_IDLE);
        cfg_ok   = cfg_we && idle;
        start    = cfg_ok && (cfg_addr == RA_SIZE);
        en_a     = mode_q[7];
        en_b     = mode_q[6];
        en_c     = mode_q[5];
        en_d     = mode_q[4];
        desc     = mode_q[0];
        width_n  = (width_q == '0) ? WMAX : {1'b0, width_q};
        height_n = (height_q == '0) ? HMAX : {1'b0, height_q};
        first_w  = (col_q == '0);
        last_w   = (col_q == width_n - COLW'(1));
        last_r   = (row_q == height_n - ROWW'(1));
        amask    = (first_w ? fmask_q : ONES) & (last_w ? lmask_q : ONES);
        a_masked = dat_a_q & amask;
    end

    blkc_shift u_shift_a (
        .cur    (a_masked),
        .prev   (prev_a_q),
        .amount (mode_q[15:12]),
        .desc   (desc),
        .out    (a_sh)
    );

    blkc_shift u_shift_b (
        .cur    (dat_b_q),
        .prev   (prev_b_q),
        .amount (mode_q[11:8]),
        .desc   (desc),
        .out    (b_sh)
    );

    blkc_minterm u_fn (
        .func (func_q),
        .a    (a_sh),
        .b    (b_sh),
        .c    (dat_c_q),
        .d    (d_val)
    );

    // word completes when the D stage finishes or is skipped
    assign word_done = (state_q == ST_WRD) && (!en_d || mem_ack);

    blkc_ptr_bank #(.AW(AW)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ptr   (cfg_ok && cfg_addr[3:2] == RA_PTR0[3:2]),
        .wr_mod   (cfg_ok && cfg_addr[3:2] == RA_MOD0[3:2]),
        .wr_sel   (cfg_addr[1:0]),
        .wr_data  (cfg_wdata),
        .step     (word_done),
        .step_en  ({en_d, en_c, en_b, en_a}),
        .line_end (last_w),
        .desc     (desc),
        .ptr_o    (ptr)
    );

    // drive the memory port from the current stage
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = d_val;
        case (state_q)
            ST_RDA: begin mem_req = en_a; mem_addr = ptr[0]; end
            ST_RDB: begin mem_req = en_b; mem_addr = ptr[1]; end
            ST_RDC: begin mem_req = en_c; mem_addr = ptr[2]; end
            ST_WRD: begin mem_req = en_d; mem_we = 1'b1; mem_addr = ptr[3]; end
            default: ;
        endcase
    end

    // sequence the stages of each word and end the job after the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_RDA;
                ST_RDA:  if (!en_a || mem_ack) state_q <= ST_RDB;
                ST_RDB:  if (!en_b || mem_ack) state_q <= ST_RDC;
                ST_RDC:  if (!en_c || mem_ack) state_q <= ST_WRD;
                ST_WRD:  if (word_done) state_q <= (last_w && last_r) ? ST_IDLE : ST_RDA;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // configuration registers written by software while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            func_q   <= '0;
            fmask_q  <= ONES;
            lmask_q  <= ONES;
            height_q <= '0;
            width_q  <= '0;
        end else if (cfg_ok) begin
            case (cfg_addr)
                RA_MODE:  mode_q  <= cfg_wdata;
                RA_FUNC:  func_q  <= cfg_wdata[7:0];
                RA_FMASK: fmask_q <= cfg_wdata;
                RA_LMASK: lmask_q <= cfg_wdata;
                RA_SIZE: begin
                    height_q <= cfg_wdata[WORD_W-1:WW];
                    width_q  <= cfg_wdata[WW-1:0];
                end
                default: ;
            endcase
        end
    end

    // source data registers: written by software or by an acknowledged fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_a_q <= '0;
            dat_b_q <= '0;
            dat_c_q <= '0;
        end else if (cfg_ok) begin
            if (cfg_addr == RA_DATA0)        dat_a_q <= cfg_wdata;
            if (cfg_addr == RA_DATA0 + 4'd1) dat_b_q <= cfg_wdata;
            if (cfg_addr == RA_DATA0 + 4'd2) dat_c_q <= cfg_wdata;
        end else if (mem_ack) begin
            if (state_q == ST_RDA) dat_a_q <= mem_rdata;
            if (state_q == ST_RDB) dat_b_q <= mem_rdata;
            if (state_q == ST_RDC) dat_c_q <= mem_rdata;
        end
    end

    // window position, shifter carry words and the all-zero tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= '0;
            row_q    <= '0;
            prev_a_q <= '0;
            prev_b_q <= '0;
            zero_q   <= 1'b0;
        end else if (start) begin
            col_q    <= '0;
            row_q    <= '0;
            prev_a_q <= '0;
            prev_b_q <= '0;
            zero_q   <= 1'b1;
        end else if (word_done) begin
            col_q    <= last_w ? '0 : col_q + COLW'(1);
            row_q    <= last_w ? row_q + ROWW'(1) : row_q;
            prev_a_q <= last_w ? '0 : a_masked;
            prev_b_q <= last_w ? '0 : dat_b_q;
            zero_q   <= zero_q && (d_val == '0);
        end
    end

    assign busy = !idle;
    assign zero = zero_q;
endmodule

// File: rtl/blkc_engine_chk.sv
// Module: protocol and status checker for blkc_engine, attached by bind.
// Observes ports only; holds no model of the datapath.
module blkc_engine_chk #(
    parameter int AW = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [3:0]                  cfg_addr,
    input logic                        mem_req,
    input logic                        mem_we,
    input logic [AW-1:0]               mem_addr,
    input logic                        mem_ack,
    input logic                        busy,
    input logic                        zero
);
    // R1: a size write while idle makes the engine busy on the next cycle
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == 4'd15 && !busy |=> busy);

    // R9: an unacknowledged request keeps its address and direction
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8: once a nonzero output is seen, zero stays low for the rest of the job
    a_r8_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !zero |=> !zero);

    // R11: no memory traffic while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R1: busy only falls after an acknowledged access or a skipped one, never mid-request
    a_r1_no_drop_mid_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> busy);
endmodule

bind blkc_engine blkc_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .zero     (zero)
);

// File: tb/blkc_engine_tb.sv
// Bench: truth-table vector loop, then directed jobs for shift, masks,
// ordering, modulo, descending order, disabled channels and the zero flag.
module blkc_engine_tb;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, zero;

    always #5 clk = ~clk;

    blkc_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .zero(zero)
    );

    // memory model: 64 words, one-cycle acknowledge, access log, bench preload
    logic [15:0] mem [64];
    logic [15:0] log_addr [256];
    logic        log_we [256];
    int          log_n = 0;
    logic        pl_we = 1'b0, pl_clr = 1'b0;
    logic [5:0]  pl_idx = '0;
    logic [15:0] pl_data = '0;
    logic        ack_q = 1'b0;
    logic [15:0] rd_q = '0;
    assign mem_ack = ack_q;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (pl_clr) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else if (pl_we) begin
            mem[pl_idx] <= pl_data;
        end else if (mem_req && !ack_q) begin
            ack_q <= 1'b1;
            rd_q  <= mem[mem_addr[6:1]];
            if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
            log_addr[log_n % 256] <= mem_addr;
            log_we[log_n % 256]   <= mem_we;
            log_n <= log_n + 1;
        end else begin
            ack_q <= 1'b0;
        end
    end

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic poke(input int idx, input logic [15:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_idx = 6'(idx); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic clear_mem();
        @(negedge clk);
        pl_clr = 1'b1;
        @(negedge clk);
        pl_clr = 1'b0;
    endtask

    task automatic run(input logic [15:0] size, input string req);
        int n;
        n = 0;
        cfg(4'd15, size);
        check(req, 16'(busy), 16'h1);
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (busy) begin
            errors++;
            $display("FAIL %s: actual busy expected idle (job timeout)", req);
        end
    endtask

    task automatic setup(input logic [15:0] mode, input logic [7:0] fn);
        cfg(4'd0, mode);
        cfg(4'd1, {8'h00, fn});
        cfg(4'd2, 16'hFFFF);
        cfg(4'd3, 16'hFFFF);
        for (int i = 8; i < 12; i++) cfg(4'(i), 16'h0000);
    endtask

    // vector: func, A, B, C, expected D (all sources from data registers)
    localparam logic [71:0] VEC [8] = '{
        {8'hF0, 16'h1234, 16'h0000, 16'h0000, 16'h1234},
        {8'h0F, 16'h1234, 16'h0000, 16'h0000, 16'hEDCB},
        {8'hFC, 16'h1200, 16'h0034, 16'h0000, 16'h1234},
        {8'hC0, 16'hFF00, 16'h0FF0, 16'h0000, 16'h0F00},
        {8'hCA, 16'hFF00, 16'h0F0F, 16'h3333, 16'h0F33},
        {8'h3C, 16'hFF00, 16'h0FF0, 16'h9999, 16'hF0F0},
        {8'hAA, 16'h0000, 16'h0000, 16'h5555, 16'h5555},
        {8'h00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000}
    };

    // global watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", 16'(busy), 16'h0);
        check("R11 zero", 16'(zero), 16'h0);
        check("R11 req", 16'(mem_req), 16'h0);
        rst_n = 1'b1;
        clear_mem();

        // R2: truth-table vectors, D only enabled, one word
        foreach (VEC[i]) begin
            setup(16'h0010, VEC[i][71:64]);
            cfg(4'd12, VEC[i][63:48]);
            cfg(4'd13, VEC[i][47:32]);
            cfg(4'd14, VEC[i][31:16]);
            cfg(4'd7, 16'h0040);
            run(16'h0041, "R2");
            check("R2 function", mem[32], VEC[i][15:0]);
        end

        // R3: A shifted right by 4 across two words
        clear_mem();
        poke(0, 16'h1234); poke(1, 16'h5678);
        setup(16'h4090, 8'hF0);
        cfg(4'd4, 16'h0000); cfg(4'd7, 16'h0040);
        run(16'h0042, "R3");
        check("R3 word0", mem[32], 16'h0123);
        check("R3 word1", mem[33], 16'h4567);

        // R4: edge masks, two-word then one-word window
        clear_mem();
        poke(0, 16'hABCD); poke(1, 16'hABCD);
        setup(16'h0090, 8'hF0);
        cfg(4'd2, 16'h0FFF); cfg(4'd3, 16'hFF00);
        cfg(4'd4, 16'h0000); cfg(4'd7, 16'h0040);
        run(16'h0042, "R4");
        check("R4 first", mem[32], 16'h0BCD);
        check("R4 last", mem[33], 16'hAB00);
        cfg(4'd4, 16'h0000); cfg(4'd7, 16'h0050);
        run(16'h0041, "R4");
        check("R4 single", mem[40], 16'h0B00);

        // R9 and R2: all channels, access order and 0xCA result
        clear_mem();
        poke(0, 16'hFF00); poke(1, 16'h0F0F); poke(2, 16'h3333);
        setup(16'h00F0, 8'hCA);
        cfg(4'd4, 16'h0000); cfg(4'd5, 16'h0002);
        cfg(4'd6, 16'h0004); cfg(4'd7, 16'h0040);
        base = log_n;
        run(16'h0041, "R9");
        check("R2 cookie", mem[32], 16'h0F33);
        check("R9 count", 16'(log_n - base), 16'd4);
        check("R9 A addr", log_addr[base % 256], 16'h0000);
        check("R9 B addr", log_addr[(base + 1) % 256], 16'h0002);
        check("R9 C addr", log_addr[(base + 2) % 256], 16'h0004);
        check("R9 D addr", log_addr[(base + 3) % 256], 16'h0040);
        check("R9 D write", 16'(log_we[(base + 3) % 256]), 16'h1);

        // R5: modulo skip and continuation without pointer reload
        clear_mem();
        poke(0, 16'hAAAA); poke(2, 16'hBBBB); poke(4, 16'hCCCC);
        setup(16'h0090, 8'hF0);
        cfg(4'd8, 16'h0002);
        cfg(4'd4, 16'h0000); cfg(4'd7, 16'h0040);
        run(16'h0081, "R5");
        check("R5 row0", mem[32], 16'hAAAA);
        check("R5 row1", mem[33], 16'hBBBB);
        run(16'h0041, "R5");
        check("R5 continue", mem[34], 16'hCCCC);

        // R10: no carry across lines
        clear_mem();
        poke(0, 16'h1234); poke(1, 16'h5678);
        setup(16'h4090, 8'hF0);
        cfg(4'd4, 16'h0000); cfg(4'd7, 16'h0040);
        run(16'h0081, "R10");
        check("R10 line0", mem[32], 16'h0123);
        check("R10 line1", mem[33], 16'h0567);

        // R6: descending with left shift by 4
        clear_mem();
        poke(0, 16'h1234); poke(1, 16'h5678);
        setup(16'h4091, 8'hF0);
        cfg(4'd4, 16'h0002); cfg(4'd7, 16'h0042);
        run(16'h0042, "R6");
        check("R6 high word", mem[33], 16'h6780);
        check("R6 low word", mem[32], 16'h2345);

        // R7: A disabled reuses its data register, no reads
        clear_mem();
        setup(16'h0010, 8'hF0);
        cfg(4'd12, 16'hBEEF);
        cfg(4'd7, 16'h0040);
        base = log_n;
        run(16'h0043, "R7");
        check("R7 w0", mem[32], 16'hBEEF);
        check("R7 w2", mem[34], 16'hBEEF);
        check("R7 writes only", 16'(log_n - base), 16'd3);

        // R8: zero flag with D disabled, then a nonzero result
        clear_mem();
        poke(32, 16'h1111);
        setup(16'h0000, 8'hC0);
        cfg(4'd12, 16'hF0F0); cfg(4'd13, 16'h0F0F);
        cfg(4'd7, 16'h0040);
        base = log_n;
        run(16'h0041, "R8");
        check("R8 zero set", 16'(zero), 16'h1);
        check("R8 no write", mem[32], 16'h1111);
        check("R8 no access", 16'(log_n - base), 16'd0);
        cfg(4'd13, 16'h00F0);
        run(16'h0041, "R8");
        check("R8 zero clear", 16'(zero), 16'h0);

        // R1: width field 0 means 64 words
        clear_mem();
        setup(16'h0010, 8'hF0);
        cfg(4'd12, 16'h5A5A);
        cfg(4'd7, 16'h0000);
        base = log_n;
        run(16'h0040, "R1");
        check("R1 64 writes", 16'(log_n - base), 16'd64);
        check("R1 first", mem[0], 16'h5A5A);
        check("R1 last", mem[63], 16'h5A5A);
        check("R1 idle after", 16'(busy), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule